// File: doc/BRIEF.md
# Dual-Port Out-of-Order Issue Queue

This block is an age-ordered holding queue for instruction tokens. An external scheduler may take entries out in any order, not only from the head. Up to two tokens can be written in per cycle through two insert ports. Up to two entries can be taken out per cycle by naming their slot index. Every slot is visible at all times, as a token plus a valid flag, so that ready-selection logic outside the queue (for example a scoreboard lookup) can decide which entries to pick.

When entries are taken out, the younger entries behind them slide toward slot 0 in the same update. The occupied slots therefore always form one unbroken run starting at slot 0, ordered oldest to youngest. New tokens are appended behind whatever survives the same cycle's removals. Insert port A counts as older than insert port B. The block reports how many slots are free and whether any are free. A build-time switch chooses whether that figure already credits the removals of the current cycle. Malformed removal requests are dropped and flagged.

Top module: `iq_ooo_queue`

## Requirements
- R1: While `rst_n` is low, every slot valid flag is cleared. After reset, `slot_vld` is 0 and `free_cnt` equals the slot count (8).
- R2: Slot i is shown as valid bit `slot_vld[i]` and token `slot_tok[i*TOK_W +: TOK_W]`. The valid slots are always a contiguous run starting at slot 0, with slot 0 holding the oldest token.
- R3: An accepted insert appears on the clock edge after it is presented, in the first slot behind the surviving entries. When both ports are accepted together, port A's token takes the lower index and port B's the next one.
- R4: A removal at valid slot k deletes that entry on the next edge. Every entry that was behind slot k moves one slot toward the head, and the relative order of all survivors is kept.
- R5: Two removals in one cycle at two different valid slots delete both entries together, and the survivors close up by up to two positions.
- R6: When inserts and removals occur in the same cycle, the new tokens are placed behind the entries that survive that cycle's removals.
- R7: With BYPASS=0, `free_cnt` = 8 − occupied slots. With BYPASS=1, `free_cnt` = 8 − (occupied slots − accepted removals of the current cycle). In both modes `not_full` is high exactly when `free_cnt` is nonzero.
- R8: Inserts are accepted only up to `free_cnt`. Port A is served first; port B is accepted only if a slot remains after port A. A refused token never enters the queue, and a full queue with no removals keeps its contents unchanged.
- R9: A removal whose index is not below the occupancy (an empty slot) is ignored, and `pick_err` is high combinationally in that same cycle.
- R10: If both removal ports name the same index, only port A's removal acts (when that slot is valid), port B is ignored, and `pick_err` is high in that cycle.
- R11: `pick_err` is low in any cycle where every active removal request is well-formed, including cycles with no removal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_a_vld | input | 1 | Insert request, older port |
| ins_a_tok | input | TOK_W | Token for older insert port |
| ins_b_vld | input | 1 | Insert request, younger port |
| ins_b_tok | input | TOK_W | Token for younger insert port |
| pick_a_vld | input | 1 | Removal request, port A |
| pick_a_idx | input | IDX_W | Slot index for removal port A |
| pick_b_vld | input | 1 | Removal request, port B |
| pick_b_idx | input | IDX_W | Slot index for removal port B |
| slot_vld | output | DEPTH | Valid flag of every slot |
| slot_tok | output | DEPTH*TOK_W | Token of every slot, slot i at bits i*TOK_W |
| free_cnt | output | CNT_W | Number of free slots for insertion this cycle |
| not_full | output | 1 | High when free_cnt is nonzero |
| pick_err | output | 1 | Malformed removal request this cycle |

## Verification
The main function is tried with single inserts on either port, dual inserts, single removals in the middle of the queue, dual removals at separated indices, and removals mixed with inserts. These cases separate correct compaction and append order from an off-by-one shift or a swapped port age. Filling to capacity and then removing while inserting tells the two free-count modes apart, because the same stimulus drives one instance of each mode. Out-of-range and duplicate indices, followed by a long stretch of random traffic, check that bad requests leave the state untouched while good ones still complete.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_SLOTS = 8;
  localparam int unsigned IQ_TOK_W = 16;

  typedef struct packed {
    logic a_ok;
    logic b_ok;
    logic err;
  } pick_dec_t;
endpackage

// File: rtl/iq_pick_check.sv
// Validates the two removal requests against the current occupancy and
// produces the keep mask used by the compaction network.
module iq_pick_check #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] occ,
  input  logic             pick_a_vld,
  input  logic [IDX_W-1:0] pick_a_idx,
  input  logic             pick_b_vld,
  input  logic [IDX_W-1:0] pick_b_idx,
  output iq_pkg::pick_dec_t dec,
  output logic [DEPTH-1:0] keep,
  output logic [1:0]       n_rm
);
  logic a_in, b_in, same, a_ok, b_ok;

  always_comb begin
    a_in = CNT_W'(pick_a_idx) < occ;
    b_in = CNT_W'(pick_b_idx) < occ;
    same = pick_a_vld && pick_b_vld && (pick_a_idx == pick_b_idx);
    a_ok = pick_a_vld && a_in;
    b_ok = pick_b_vld && b_in && !same;
    dec.a_ok = a_ok;
    dec.b_ok = b_ok;
    dec.err  = (pick_a_vld && !a_in) || (pick_b_vld && (!b_in || same));
    n_rm     = {1'b0, a_ok} + {1'b0, b_ok};
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_keep
    assign keep[s] = !((a_ok && (pick_a_idx == IDX_W'(s))) ||
                       (b_ok && (pick_b_idx == IDX_W'(s))));
  end
endmodule

// File: rtl/iq_compact.sv
// Moves every kept entry to the slot given by the number of kept entries below it.
module iq_compact #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TOK_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*TOK_W-1:0] tok_in,
  input  logic [DEPTH-1:0]       keep,
  output logic [DEPTH*TOK_W-1:0] tok_out
);
  logic [CNT_W-1:0] rank [DEPTH];

  always_comb begin
    rank[0] = '0;
    for (int p = 1; p < DEPTH; p++) begin
      rank[p] = rank[p-1] + CNT_W'(keep[p-1]);
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_dst
    always_comb begin
      tok_out[d*TOK_W +: TOK_W] = '0;
      for (int p = d; p < DEPTH; p++) begin
        if (keep[p] && (rank[p] == CNT_W'(d))) begin
          tok_out[d*TOK_W +: TOK_W] = tok_in[p*TOK_W +: TOK_W];
        end
      end
    end
  end
endmodule

// File: rtl/iq_fill.sv
// Computes free space, accepts inserts and appends them behind the survivors.
module iq_fill #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TOK_W  = 16,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]       occ,
  input  logic [1:0]             n_rm,
  input  logic [DEPTH*TOK_W-1:0] cmp_tok,
  input  logic                   ins_a_vld,
  input  logic [TOK_W-1:0]       ins_a_tok,
  input  logic                   ins_b_vld,
  input  logic [TOK_W-1:0]       ins_b_tok,
  output logic [DEPTH*TOK_W-1:0] nxt_tok,
  output logic [DEPTH-1:0]       nxt_vld,
  output logic [CNT_W-1:0]       free_cnt
);
  logic [CNT_W-1:0] surv, pos_a, pos_b, new_cnt;
  logic             acc_a, acc_b;

  always_comb begin
    surv = occ - CNT_W'(n_rm);
    if (BYPASS) free_cnt = CNT_W'(DEPTH) - surv;
    else        free_cnt = CNT_W'(DEPTH) - occ;
    acc_a   = ins_a_vld && (free_cnt != '0);
    acc_b   = ins_b_vld && (acc_a ? (free_cnt >= CNT_W'(2)) : (free_cnt != '0));
    pos_a   = surv;
    pos_b   = surv + CNT_W'(acc_a);
    new_cnt = surv + CNT_W'(acc_a) + CNT_W'(acc_b);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_comb begin
      nxt_vld[s] = CNT_W'(s) < new_cnt;
      if (acc_a && (pos_a == CNT_W'(s)))      nxt_tok[s*TOK_W +: TOK_W] = ins_a_tok;
      else if (acc_b && (pos_b == CNT_W'(s))) nxt_tok[s*TOK_W +: TOK_W] = ins_b_tok;
      else                                    nxt_tok[s*TOK_W +: TOK_W] = cmp_tok[s*TOK_W +: TOK_W];
    end
  end
endmodule

// File: rtl/iq_ooo_queue.sv
// Top: slot registers plus the removal, compaction and fill stages.
// rst_n is expected to be deasserted synchronously by the reset tree.
module iq_ooo_queue #(
  parameter int unsigned DEPTH  = iq_pkg::IQ_SLOTS,
  parameter int unsigned TOK_W  = iq_pkg::IQ_TOK_W,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_a_vld,
  input  logic [TOK_W-1:0]       ins_a_tok,
  input  logic                   ins_b_vld,
  input  logic [TOK_W-1:0]       ins_b_tok,
  input  logic                   pick_a_vld,
  input  logic [IDX_W-1:0]       pick_a_idx,
  input  logic                   pick_b_vld,
  input  logic [IDX_W-1:0]       pick_b_idx,
  output logic [DEPTH-1:0]       slot_vld,
  output logic [DEPTH*TOK_W-1:0] slot_tok,
  output logic [CNT_W-1:0]       free_cnt,
  output logic                   not_full,
  output logic                   pick_err
);
  logic [DEPTH-1:0]       vld_q, vld_d;
  logic [DEPTH*TOK_W-1:0] tok_q, tok_d, cmp_tok;
  logic [DEPTH-1:0]       keep;
  logic [1:0]             n_rm;
  logic [CNT_W-1:0]       occ;
  iq_pkg::pick_dec_t      dec;

  assign occ = CNT_W'($countones(vld_q));

  iq_pick_check #(.DEPTH(DEPTH)) u_pick (
    .occ(occ), .pick_a_vld(pick_a_vld), .pick_a_idx(pick_a_idx),
    .pick_b_vld(pick_b_vld), .pick_b_idx(pick_b_idx),
    .dec(dec), .keep(keep), .n_rm(n_rm)
  );

  iq_compact #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_cmp (
    .tok_in(tok_q), .keep(keep), .tok_out(cmp_tok)
  );

  iq_fill #(.DEPTH(DEPTH), .TOK_W(TOK_W), .BYPASS(BYPASS)) u_fill (
    .occ(occ), .n_rm(n_rm), .cmp_tok(cmp_tok),
    .ins_a_vld(ins_a_vld), .ins_a_tok(ins_a_tok),
    .ins_b_vld(ins_b_vld), .ins_b_tok(ins_b_tok),
    .nxt_tok(tok_d), .nxt_vld(vld_d), .free_cnt(free_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Token storage carries no reset; a slot loads only when it will hold an entry.
  for (genvar s = 0; s < DEPTH; s++) begin : g_tok
    always_ff @(posedge clk) begin
      if (vld_d[s]) tok_q[s*TOK_W +: TOK_W] <= tok_d[s*TOK_W +: TOK_W];
    end
  end

  assign slot_vld = vld_q;
  assign slot_tok = tok_q;
  assign not_full = free_cnt != '0;
  assign pick_err = dec.err;
endmodule

// File: rtl/iq_ooo_queue_chk.sv
module iq_ooo_queue_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TOK_W  = 16,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pick_a_vld,
  input logic [IDX_W-1:0]       pick_a_idx,
  input logic                   pick_b_vld,
  input logic [IDX_W-1:0]       pick_b_idx,
  input logic [DEPTH-1:0]       slot_vld,
  input logic [DEPTH*TOK_W-1:0] slot_tok,
  input logic [CNT_W-1:0]       free_cnt,
  input logic                   not_full,
  input logic                   pick_err
);
  int occ_c;
  assign occ_c = $countones(slot_vld);

  p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld & (slot_vld + DEPTH'(1))) == '0);

  p_head_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[0] && !(pick_a_vld && pick_a_idx == '0) && !(pick_b_vld && pick_b_idx == '0)
    |=> slot_vld[0] && (slot_tok[TOK_W-1:0] == $past(slot_tok[TOK_W-1:0])));

  p_notfull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    not_full == (free_cnt != '0));

  if (!BYPASS) begin : g_plain
    p_free_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_cnt) == int'(DEPTH) - occ_c);
  end

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !not_full && !pick_a_vld && !pick_b_vld |=> $stable(slot_vld) && $stable(slot_tok));

  p_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occ_c <= $past(occ_c) + 2);

  p_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pick_a_vld && !slot_vld[pick_a_idx] |-> pick_err);

  p_same_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pick_a_vld && pick_b_vld && (pick_a_idx == pick_b_idx) |-> pick_err);
endmodule

bind iq_ooo_queue iq_ooo_queue_chk #(.DEPTH(DEPTH), .TOK_W(TOK_W), .BYPASS(BYPASS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pick_a_vld(pick_a_vld), .pick_a_idx(pick_a_idx),
  .pick_b_vld(pick_b_vld), .pick_b_idx(pick_b_idx),
  .slot_vld(slot_vld), .slot_tok(slot_tok),
  .free_cnt(free_cnt), .not_full(not_full), .pick_err(pick_err)
);

// File: tb/tb_iq_ooo_queue.sv
`timescale 1ns/1ps
module tb_iq_ooo_queue;
  localparam int N  = 8;
  localparam int TW = 16;

  logic clk, rst_n;
  logic ins_a_vld, ins_b_vld, pick_a_vld, pick_b_vld;
  logic [TW-1:0] ins_a_tok, ins_b_tok;
  logic [2:0] pick_a_idx, pick_b_idx;

  logic [N-1:0]    o_vld  [2];
  logic [N*TW-1:0] o_tok  [2];
  logic [3:0]      o_free [2];
  logic            o_nf   [2];
  logic            o_err  [2];

  int checks, fails;
  bit done;

  // Reference state per instance: 0 = plain free count, 1 = bypass free count
  logic [TW-1:0] mt [2][N];
  int  mc [2];
  bit  m_aok [2], m_bok [2], m_acca [2], m_accb [2], m_err [2];
  int  m_free [2];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  iq_ooo_queue #(.BYPASS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n),
    .ins_a_vld(ins_a_vld), .ins_a_tok(ins_a_tok), .ins_b_vld(ins_b_vld), .ins_b_tok(ins_b_tok),
    .pick_a_vld(pick_a_vld), .pick_a_idx(pick_a_idx), .pick_b_vld(pick_b_vld), .pick_b_idx(pick_b_idx),
    .slot_vld(o_vld[0]), .slot_tok(o_tok[0]), .free_cnt(o_free[0]), .not_full(o_nf[0]), .pick_err(o_err[0])
  );

  iq_ooo_queue #(.BYPASS(1'b1)) dut_byp (
    .clk(clk), .rst_n(rst_n),
    .ins_a_vld(ins_a_vld), .ins_a_tok(ins_a_tok), .ins_b_vld(ins_b_vld), .ins_b_tok(ins_b_tok),
    .pick_a_vld(pick_a_vld), .pick_a_idx(pick_a_idx), .pick_b_vld(pick_b_vld), .pick_b_idx(pick_b_idx),
    .slot_vld(o_vld[1]), .slot_tok(o_tok[1]), .free_cnt(o_free[1]), .not_full(o_nf[1]), .pick_err(o_err[1])
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic model_comb(int k);
    int occ, ai, bi, nr, surv;
    bit ain, bin, same;
    occ  = mc[k];
    ai   = int'(pick_a_idx);
    bi   = int'(pick_b_idx);
    ain  = ai < occ;
    bin  = bi < occ;
    same = pick_a_vld && pick_b_vld && (ai == bi);
    m_aok[k] = pick_a_vld && ain;
    m_bok[k] = pick_b_vld && bin && !same;
    m_err[k] = (pick_a_vld && !ain) || (pick_b_vld && (!bin || same));
    nr   = int'(m_aok[k]) + int'(m_bok[k]);
    surv = occ - nr;
    m_free[k] = (k == 1) ? N - surv : N - occ;
    m_acca[k] = ins_a_vld && (m_free[k] > 0);
    m_accb[k] = ins_b_vld && (m_acca[k] ? (m_free[k] >= 2) : (m_free[k] > 0));
  endtask

  task automatic model_commit(int k);
    logic [TW-1:0] nt [N];
    int j;
    j = 0;
    for (int p = 0; p < N; p++) nt[p] = '0;
    for (int p = 0; p < mc[k]; p++) begin
      if (!((m_aok[k] && p == int'(pick_a_idx)) || (m_bok[k] && p == int'(pick_b_idx)))) begin
        nt[j] = mt[k][p];
        j++;
      end
    end
    if (m_acca[k]) begin nt[j] = ins_a_tok; j++; end
    if (m_accb[k]) begin nt[j] = ins_b_tok; j++; end
    for (int p = 0; p < N; p++) mt[k][p] = nt[p];
    mc[k] = j;
  endtask

  task automatic check_state(string tag, int k);
    logic [N-1:0]    ev;
    logic [N*TW-1:0] et, at;
    ev = '0; et = '0; at = '0;
    for (int i = 0; i < mc[k]; i++) begin
      ev[i] = 1'b1;
      et[i*TW +: TW] = mt[k][i];
      at[i*TW +: TW] = o_tok[k][i*TW +: TW];
    end
    checks++;
    if (o_vld[k] !== ev || at !== et) begin
      fails++;
      $display("FAIL %s inst%0d slots: vld act=%b exp=%b tok act=%h exp=%h", tag, k, o_vld[k], ev, at, et);
    end
  endtask

  task automatic check_comb(string tag, int k);
    checks++;
    if (int'(o_free[k]) != m_free[k] || o_nf[k] !== (m_free[k] != 0)) begin
      fails++;
      $display("FAIL R7 (%s) inst%0d free_cnt/not_full act=%0d/%b exp=%0d/%b",
               tag, k, o_free[k], o_nf[k], m_free[k], m_free[k] != 0);
    end
    checks++;
    if (o_err[k] !== m_err[k]) begin
      fails++;
      $display("FAIL %s (R9/R10/R11) inst%0d pick_err act=%b exp=%b", tag, k, o_err[k], m_err[k]);
    end
  endtask

  task automatic cyc(string tag, bit av, logic [TW-1:0] at, bit bv, logic [TW-1:0] bt,
                     bit pav, int pai, bit pbv, int pbi);
    @(negedge clk);
    ins_a_vld = av;  ins_a_tok = at;
    ins_b_vld = bv;  ins_b_tok = bt;
    pick_a_vld = pav; pick_a_idx = 3'(pai);
    pick_b_vld = pbv; pick_b_idx = 3'(pbi);
    #2;
    for (int k = 0; k < 2; k++) begin
      model_comb(k);
      check_comb(tag, k);
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      model_commit(k);
      check_state(tag, k);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    mc[0] = 0; mc[1] = 0;
    ins_a_vld = 0; ins_b_vld = 0; pick_a_vld = 0; pick_b_vld = 0;
    ins_a_tok = '0; ins_b_tok = '0; pick_a_idx = '0; pick_b_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: empty after reset
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (o_vld[k] !== '0 || o_free[k] !== 4'd8) begin
        fails++;
        $display("FAIL R1 inst%0d after reset vld=%b free=%0d exp vld=0 free=8", k, o_vld[k], o_free[k]);
      end
    end

    cyc("R3", 1, 16'hA001, 0, 16'h0,    0, 0, 0, 0);
    cyc("R3", 0, 16'h0,    1, 16'hB001, 0, 0, 0, 0);
    cyc("R3", 1, 16'hA002, 1, 16'hB002, 0, 0, 0, 0);
    cyc("R8", 1, 16'hA003, 1, 16'hB003, 0, 0, 0, 0);
    cyc("R8", 1, 16'hA004, 1, 16'hB004, 0, 0, 0, 0);
    cyc("R8", 1, 16'hA005, 1, 16'hB005, 0, 0, 0, 0);
    cyc("R7", 1, 16'hA006, 1, 16'hB006, 1, 2, 0, 0);
    cyc("R4", 0, 16'h0,    0, 16'h0,    1, 3, 0, 0);
    cyc("R5", 0, 16'h0,    0, 16'h0,    1, 1, 1, 5);
    cyc("R6", 1, 16'hA007, 1, 16'hB007, 1, 0, 0, 0);
    cyc("R10", 0, 16'h0,   0, 16'h0,    1, 2, 1, 2);
    cyc("R9", 0, 16'h0,    0, 16'h0,    1, 7, 1, 6);
    cyc("R11", 0, 16'h0,   0, 16'h0,    1, 0, 1, 1);
    cyc("R6", 1, 16'hA008, 0, 16'h0,    0, 0, 1, 0);
    repeat (5) cyc("R5", 0, 16'h0, 0, 16'h0, 1, 0, 1, 1);
    cyc("R9", 0, 16'h0,    0, 16'h0,    1, 0, 0, 0);
    cyc("R10", 1, 16'hA009, 0, 16'h0,   1, 0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      cyc("R2", 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
          1'($urandom), int'($urandom_range(0, 7)), 1'($urandom), int'($urandom_range(0, 7)));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule